// File: doc/BRIEF.md
# Sticky interrupt flag register with acknowledge on read

This block collects single-cycle event pulses from several interrupt sources inside a timer or I/O peripheral. Each pulse sets a flag bit that stays set until the processor acknowledges it. A mask register chooses which pending flags may pull the shared active-low interrupt request line. Several peripherals can share that line, because each one only contributes its own request to it.

The processor reaches the block through one register location. A read returns the pending flags in the low bits and an interrupt summary bit in the top bit. The same read acknowledges all flags and releases the request line. A write updates the mask. The top bit of the written value decides whether the selected mask bits are set or cleared.

The summary and the request line are registered. They follow the flags one cycle late. A read that lands in that one-cycle gap sees the flag without the summary bit, and the interrupt it would have raised never appears. The model uses one clock domain, with one processor bus cycle per clock.

Top module: `event_irq_reg`

## Requirements
- R1: After reset, all flags and all mask bits are zero, irqN is high, and a read returns 8'h00.
- R2: A high srcEvent[i] in a cycle sets flag bit i at the following edge. The flag stays set through any number of non-read cycles and appears as bit i of the read value.
- R3: irqN is low in a cycle exactly when, at the previous edge, some flag was set with its mask bit set and that cycle was not a read. Bit 7 of a read value equals the inverted irqN level of that cycle.
- R4: A read (busEn=1, busWr=0) returns {summary, flags} in the same cycle. It clears every flag that was set before the read, and irqN is high in the next cycle.
- R5: If source 1 pulses in cycle e and the read falls in cycle e+1, the read returns 8'h02 and irqN never goes low for that event. A read in cycle e+2 or later returns 8'h82.
- R6: An event pulse that arrives in the same cycle as a read is not lost. That read does not show it, the next read does, and with its mask bit set it drives irqN low two cycles after the pulse.
- R7: A write (busEn=1, busWr=1) with data bit 7 = 1 sets the mask bits that are 1 in data bits 6..0. With bit 7 = 0 it clears them. Mask bits whose data bit is 0 are unchanged. So 8'h7F disables every source, and 8'h7E leaves only source 0 as it was.
- R8: A flag latches even while its mask bit is clear. If its mask bit is then set by a write in cycle w, irqN goes low in cycle w+2. Clearing the mask in cycle w raises irqN in cycle w+2.
- R9: Pending flags of several enabled sources combine into one request. A read returns all of them together with bit 7.
- R10: When there is no read, rdData is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bus cycle per period |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC (7) | One pulse per source event; bit i belongs to source i |
| busEn | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write the mask, 0 = read and acknowledge the flags |
| wrData | input | DATA_W (8) | Mask update: bit 7 selects set or clear, the low bits select sources |
| rdData | output | DATA_W (8) | Bit 7 is the summary, the low bits are the flags; zero when there is no read |
| irqN | output | 1 | Active-low shared interrupt request |

## Verification
The acknowledging read can coincide with a new event pulse, and it can also coincide with the one-cycle promotion of a fresh flag into the summary bit and irqN. A directed sweep moves the source-1 pulse from two cycles after the read to four cycles before it. For each position the bench judges the read value (00, 02 or 82) and whether irqN went low at any time in a window that reaches well past both events. Random traffic with sparse pulses and frequent reads and mask writes also produces these collisions, and a cycle-level bench model judges every sample.

// File: rtl/event_irq_pkg.sv
package event_irq_pkg;

  // Strobes that the bus decoder hands to the flag datapath each cycle.
  typedef struct packed {
    logic ackRead;      // read access: return flags, then clear them
    logic maskWrite;    // write access: update the mask
    logic maskSetMode;  // 1 = set selected mask bits, 0 = clear them
  } flagCtrlT;

endpackage

// File: rtl/event_irq_ctrl.sv
module event_irq_ctrl
  import event_irq_pkg::*;
(
  input  logic     busEn,
  input  logic     busWr,
  input  logic     modeBit,
  output flagCtrlT ctrl
);

  always_comb begin
    ctrl.ackRead     = busEn & ~busWr;
    ctrl.maskWrite   = busEn & busWr;
    ctrl.maskSetMode = modeBit;
  end

endmodule

// File: rtl/event_irq_dp.sv
module event_irq_dp
  import event_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] selBits,
  input  flagCtrlT           ctrl,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqQ
);

  logic anyEnabled;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // Flag bit: a new event wins over the acknowledge in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN)
        flagQ[i] <= 1'b0;
      else if (srcEvent[i])
        flagQ[i] <= 1'b1;
      else if (ctrl.ackRead)
        flagQ[i] <= 1'b0;
    end

    // Mask bit: touched only when its select bit is one.
    always_ff @(posedge clk) begin
      if (!rstN)
        maskQ[i] <= 1'b0;
      else if (ctrl.maskWrite && selBits[i])
        maskQ[i] <= ctrl.maskSetMode;
    end
  end

  assign anyEnabled = |(flagQ & maskQ);

  // The summary is one cycle behind the flags. A read in the gap suppresses it.
  always_ff @(posedge clk) begin
    if (!rstN)
      irqQ <= 1'b0;
    else
      irqQ <= anyEnabled & ~ctrl.ackRead;
  end

endmodule

// File: rtl/event_irq_reg.sv
module event_irq_reg
  import event_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               busEn,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqN
);

  localparam int SumBit = DATA_W - 1;

  flagCtrlT           ctrl;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               irqQ;

  event_irq_ctrl u_ctrl (
    .busEn   (busEn),
    .busWr   (busWr),
    .modeBit (wrData[SumBit]),
    .ctrl    (ctrl)
  );

  event_irq_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcEvent (srcEvent),
    .selBits  (wrData[NUM_SRC-1:0]),
    .ctrl     (ctrl),
    .flagQ    (flagQ),
    .maskQ    (maskQ),
    .irqQ     (irqQ)
  );

  always_comb begin
    rdData = '0;
    if (ctrl.ackRead) begin
      rdData[NUM_SRC-1:0] = flagQ;
      rdData[SumBit]      = irqQ;
    end
  end

  assign irqN = ~irqQ;

endmodule

// File: rtl/event_irq_chk.sv
module event_irq_chk #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic               busEn,
  input logic               busWr,
  input logic [DATA_W-1:0]  rdData,
  input logic               irqN,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] maskQ
);

  logic rd;
  assign rd = busEn && !busWr;

  // R4: a read always releases the request line in the next cycle.
  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    rd |=> irqN);

  // R3: the summary bit seen by a read matches the line.
  a_r3_summary_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rd |-> (rdData[DATA_W-1] == !irqN));

  // R3: the line is low only if an enabled flag was pending one cycle earlier.
  a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> $past(|(flagQ & maskQ)));

  // R2: without a read, no flag ever drops.
  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !rd |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R6: after a read, exactly the events of the read cycle remain.
  a_r6_event_in_read_kept: assert property (@(posedge clk) disable iff (!rstN)
    rd |=> (flagQ == $past(srcEvent)));

  // R10: rdData is quiet without a read.
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rd |-> (rdData == '0));

endmodule

bind event_irq_reg event_irq_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .srcEvent (srcEvent),
  .busEn    (busEn),
  .busWr    (busWr),
  .rdData   (rdData),
  .irqN     (irqN),
  .flagQ    (u_dp.flagQ),
  .maskQ    (u_dp.maskQ)
);

// File: tb/event_irq_reg_bench.sv
module event_irq_reg_bench;

  localparam int NS = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcEvent = '0;
  logic          busEn = 1'b0;
  logic          busWr = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          irqN;

  int checks = 0;
  int failures = 0;

  // Bench model state
  logic [NS-1:0] mFlags = '0;
  logic [NS-1:0] mMask = '0;
  logic          mIrq = 1'b0;

  always #5 clk = ~clk;

  event_irq_reg #(.NUM_SRC(NS), .DATA_W(DW)) u_event_irq_reg (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .busEn(busEn),
    .busWr(busWr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  function automatic logic [DW-1:0] expRead(input logic [NS-1:0] f, input logic s);
    logic [DW-1:0] v;
    v = '0;
    v[NS-1:0] = f;
    v[DW-1] = s;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus cycle; starts and ends at a falling edge. Model-checks every cycle.
  task automatic cyc(input logic en, input logic wr, input logic [DW-1:0] d,
                     input logic [NS-1:0] ev, output logic [DW-1:0] rv, output logic iv);
    logic rd;
    logic [NS-1:0] nf;
    busEn = en; busWr = wr; wrData = d; srcEvent = ev;
    #1;
    rv = rdData; iv = irqN;
    rd = en && !wr;
    check("R4", rdData, rd ? expRead(mFlags, mIrq) : '0, "rdData vs model");
    check("R3", irqN, !mIrq, "irqN vs model");
    nf = (rd ? '0 : mFlags) | ev;
    mIrq = (|(mFlags & mMask)) && !rd;
    mFlags = nf;
    if (en && wr) begin
      for (int i = 0; i < NS; i++)
        if (d[i]) mMask[i] = d[DW-1];
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic [DW-1:0] rv; logic iv;
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, rv, iv);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    logic iv;
    logic seen;
    logic [DW-1:0] got;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1", irqN, 1'b1, "irqN after reset");
    cyc(1, 0, '0, '0, rv, iv);
    check("R1", rv, 8'h00, "read after reset");

    // R8 and R7: a masked flag latches but stays silent; enabling it raises irqN at w+2
    cyc(0, 0, '0, 7'h02, rv, iv);
    idle(3);
    check("R8", irqN, 1'b1, "irqN with flag masked");
    cyc(1, 1, 8'h82, '0, rv, iv);
    check("R8", irqN, 1'b1, "irqN at w+1");
    idle(1);
    check("R8", irqN, 1'b0, "irqN at w+2 after enable");
    // R7: 7E clears bit 1, source 0 is untouched (still clear)
    cyc(1, 1, 8'h7E, '0, rv, iv);
    idle(1);
    check("R7", irqN, 1'b1, "irqN after 7E clear");
    cyc(1, 1, 8'h81, '0, rv, iv);
    cyc(1, 1, 8'h7E, '0, rv, iv);
    cyc(0, 0, '0, 7'h01, rv, iv);
    idle(2);
    check("R7", irqN, 1'b0, "source 0 kept by 7E");
    // R9: several enabled flags share the request
    cyc(1, 1, 8'h82, '0, rv, iv);
    idle(2);
    cyc(1, 0, '0, '0, rv, iv);
    check("R9", rv, 8'h83, "read with two flags");
    idle(1);
    check("R4", irqN, 1'b1, "irqN after acknowledge");
    // R2: sticky over many cycles
    cyc(0, 0, '0, 7'h40, rv, iv);
    idle(20);
    cyc(1, 0, '0, '0, rv, iv);
    check("R2", rv, 8'h40, "sticky flag 6 (masked)");
    // R7: 7F disables all
    cyc(1, 1, 8'h7F, '0, rv, iv);
    cyc(0, 0, '0, 7'h7F, rv, iv);
    idle(3);
    check("R7", irqN, 1'b1, "irqN after 7F");
    cyc(1, 0, '0, '0, rv, iv);
    check("R7", rv, 8'h7F, "flags still latch under 7F");

    // R5/R6 sweep: source 1 pulses at cycle 4, read at 4+d
    cyc(1, 1, 8'h82, '0, rv, iv);
    for (int d = -2; d <= 4; d++) begin
      cyc(1, 0, '0, '0, rv, iv);
      idle(2);
      seen = 1'b0;
      got = '0;
      for (int c = 0; c <= 12; c++) begin
        cyc(c == 4 + d, 0, '0, (c == 4) ? 7'h02 : 7'h00, rv, iv);
        if (c == 4 + d) got = rv;
        if (!iv) seen = 1'b1;
      end
      if (d < 0) begin
        check("R6", got, 8'h00, "read before event");
        check("R6", seen, 1'b1, "irq after early read");
      end else if (d == 0) begin
        check("R6", got, 8'h00, "read in event cycle");
        check("R6", seen, 1'b1, "event in read cycle kept");
      end else if (d == 1) begin
        check("R5", got, 8'h02, "read in gap");
        check("R5", seen, 1'b0, "irq suppressed");
      end else begin
        check("R5", got, 8'h82, "read after summary");
        check("R5", seen, 1'b1, "irq seen before read");
      end
    end

    // R10 and random traffic against the model
    cyc(0, 0, '0, 7'h10, rv, iv);
    check("R10", rv, 8'h00, "no read, quiet bus");
    for (int n = 0; n < 600; n++) begin
      logic en, wr;
      logic [NS-1:0] ev;
      en = ($urandom % 4) == 0;
      wr = en && (($urandom % 3) == 0);
      ev = (($urandom % 5) == 0) ? NS'(1 << ($urandom % NS)) : '0;
      cyc(en, wr, DW'($urandom), ev, rv, iv);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule